// File: doc/BRIEF.md
# Odd/Even Clock Post-Divider

This block turns one of two incoming clocks, a VCO clock or a reference clock, into a single output clock. The selected source first passes through a counter that divides by any whole ratio from 1 to 31, odd or even. The counter works on both edges of the source clock, so odd ratios still give a balanced output. A second stage can then divide by 1, 2, 4 or 8. The total division is the counter ratio times that factor.

A two-bit source mode picks one of four outputs:
- VCO divided by the counter ratio only;
- VCO divided by the counter ratio and the power-of-two stage;
- the reference clock passed straight through;
- the reference divided by the counter ratio and the power-of-two stage.

Some output positions on a chip only need VCO division by the counter ratio. For those, a parameter removes the reference path and the power-of-two stage completely.

A new ratio can be written at any time. It is taken up only when the current divided period ends, so a change never produces a truncated pulse.

Top module: `clkdiv_top`

## Requirements
- R1: The counter ratio N equals `p_val` (5 bits, 1 to 31). A `p_val` of 0 gives N = 1. In mode 0 (VCO divided) the output period is N VCO periods.
- R2: For every N, odd or even, the output high time is N/2 source periods, which keeps the duty cycle within 45% to 55%. An odd N gets its extra half period from a copy of the counter output taken on the falling edge.
- R3: `pow_sel` codes 0, 1, 2 and 3 divide the counter output further by 1, 2, 4 and 8. The output period is N·2^code source periods.
- R4: `src_mode` selects the output:
  - 0: VCO/N, with `pow_sel` ignored;
  - 1: VCO/(N·2^code);
  - 2: the reference clock unchanged, with `p_val` and `pow_sel` ignored;
  - 3: reference/(N·2^code).
- R5: While `rst_n` is low, the output is low in every mode except mode 2.
- R6: A change of `p_val` made partway through an output period takes effect only after that period ends. The period in progress keeps its old high time and its old length.
- R7: With `FULL_PATHS` = 0, the output is always VCO/N. `src_mode`, `pow_sel` and `ref_clk` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | VCO clock source |
| ref_clk | input | 1 | Reference clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_val | input | 5 | Counter ratio, 0 treated as 1 |
| pow_sel | input | 2 | Power-of-two stage code (factor 2^code) |
| src_mode | input | 2 | Source and path select (R4 encoding) |
| clk_out | output | 1 | Divided output clock |

## Verification
Three sweeps measure the output period and the high time:
- Every counter ratio from 0 to 31 with every power-of-two code on the VCO. This separates errors in the counter from errors in the post stage, and odd ratios from even ones.
- The same ratios on the reference path. Its clock period differs from the VCO period, which exposes any wrong choice of source clock.
- The VCO-only mode with a nonzero `pow_sel`, and the reduced variant fed with reference modes. Both show that the ignored inputs really have no effect.

A ratio written partway through a period separates taking the new ratio at the period boundary from taking it at once.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   typedef enum logic [1:0] {
      SRC_VCO_DIV    = 2'd0,
      SRC_VCO_DIVPOW = 2'd1,
      SRC_REF_THRU   = 2'd2,
      SRC_REF_DIVPOW = 2'd3
   } src_mode_e;
endpackage

// File: rtl/clkdiv_oddeven.sv
module clkdiv_oddeven #(
   parameter int P_W = 5
) (
   input  logic           ci,
   input  logic           rst_n,
   input  logic [P_W-1:0] p_val,
   output logic           co
);
   localparam logic [P_W-1:0] ONE     = P_W'(1);
   localparam logic [P_W-1:0] RST_DIV = P_W'(2);

   if (P_W < 2) begin : g_bad_width
      $error("clkdiv_oddeven: P_W must be at least 2");
   end

   logic [P_W-1:0] n_cur, cnt, n_req, n_nxt, cnt_nxt;
   logic           wrap, pos_q, neg_q, bypass;

   // Ratio is only reloaded when the running period finishes
   always_comb begin
      n_req   = (p_val == '0) ? ONE : p_val;
      wrap    = (cnt == n_cur - ONE);
      n_nxt   = wrap ? n_req : n_cur;
      cnt_nxt = wrap ? '0 : cnt + ONE;
   end

   always_ff @(posedge ci or negedge rst_n) begin
      if (!rst_n) begin
         n_cur <= RST_DIV;
         cnt   <= '0;
         pos_q <= 1'b0;
      end else begin
         n_cur <= n_nxt;
         cnt   <= cnt_nxt;
         pos_q <= (cnt_nxt < (n_nxt >> 1));
      end
   end

   // Half-period delayed copy stretches the high phase for odd ratios
   always_ff @(negedge ci or negedge rst_n) begin
      if (!rst_n) neg_q <= 1'b0;
      else        neg_q <= pos_q;
   end

   assign bypass = (n_cur == ONE);
   assign co     = bypass ? ci : (pos_q | (n_cur[0] & neg_q));

   p_cnt_bound_r1: assert property (@(posedge ci) disable iff (!rst_n)
      cnt < n_cur);

   p_reload_at_end_r6: assert property (@(posedge ci) disable iff (!rst_n)
      (n_cur != $past(n_cur)) |-> ($past(cnt) == $past(n_cur) - ONE));

   p_rise_at_start_r2: assert property (@(posedge ci) disable iff (!rst_n)
      $rose(pos_q) |-> (cnt == '0));
endmodule

// File: rtl/clkdiv_pow2.sv
module clkdiv_pow2 #(
   parameter int SEL_W = 2
) (
   input  logic             ci,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             co
);
   localparam int TAPS = 1 << SEL_W;
   localparam int CW   = TAPS - 1;

   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("clkdiv_pow2: SEL_W must be 1 to 3");
   end

   logic [CW-1:0]   cnt;
   logic            armed;
   logic [TAPS-1:0] tap;

   always_ff @(posedge ci or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else begin
         cnt   <= cnt + CW'(1);
         armed <= 1'b1;
      end
   end

   assign tap[0] = ci;
   for (genvar i = 1; i < TAPS; i++) begin : g_tap
      assign tap[i] = cnt[i-1];
   end

   assign co = tap[sel];

   p_pow_step_r3: assert property (@(posedge ci) disable iff (!rst_n)
      armed |-> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
   parameter int P_W        = 5,
   parameter int POW_W      = 2,
   parameter bit FULL_PATHS = 1'b1
) (
   input  logic             vco_clk,
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic [P_W-1:0]   p_val,
   input  logic [POW_W-1:0] pow_sel,
   input  logic [1:0]       src_mode,
   output logic             clk_out
);
   import clkdiv_pkg::*;

   src_mode_e mode;
   logic      src_clk, p_out;

   assign mode = src_mode_e'(src_mode);

   if (FULL_PATHS) begin : g_full
      logic [POW_W-1:0] pow_eff;
      logic             pow_out;

      assign src_clk = (mode == SRC_REF_THRU || mode == SRC_REF_DIVPOW) ? ref_clk : vco_clk;
      assign pow_eff = (mode == SRC_VCO_DIV) ? '0 : pow_sel;

      clkdiv_pow2 #(.SEL_W(POW_W)) i_pow (
         .ci(p_out), .rst_n(rst_n), .sel(pow_eff), .co(pow_out)
      );

      assign clk_out = (mode == SRC_REF_THRU) ? ref_clk : pow_out;
   end else begin : g_lite
      assign src_clk = vco_clk;
      assign clk_out = p_out;
   end

   clkdiv_oddeven #(.P_W(P_W)) i_pdiv (
      .ci(src_clk), .rst_n(rst_n), .p_val(p_val), .co(p_out)
   );
endmodule

// File: tb/test_clkdiv_top.sv
`timescale 1ns/1ps
module test_clkdiv_top;
   localparam real TV = 20.0;
   localparam real TR = 30.0;

   logic       vco_clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic [4:0] p_val   = 5'd4;
   logic [1:0] pow_sel = 2'd0;
   logic [1:0] src_mode = 2'd1;
   logic       clk_out, lite_out;

   int n_checks = 0;
   int n_fail   = 0;

   always #(TV/2) vco_clk = ~vco_clk;
   always #(TR/2) ref_clk = ~ref_clk;

   clkdiv_top i_clkdiv_top (
      .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .p_val(p_val),
      .pow_sel(pow_sel), .src_mode(src_mode), .clk_out(clk_out)
   );

   clkdiv_top #(.FULL_PATHS(1'b0)) i_clkdiv_lite (
      .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .p_val(p_val),
      .pow_sel(pow_sel), .src_mode(src_mode), .clk_out(lite_out)
   );

   task automatic check(input bit ok, input string req, input real act, input real exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0.3f expected %0.3f", req, act, exp);
      end
   endtask

   task automatic wait_edge(input bit lite, input bit rise);
      if (lite) begin
         if (rise) @(posedge lite_out); else @(negedge lite_out);
      end else begin
         if (rise) @(posedge clk_out); else @(negedge clk_out);
      end
   endtask

   task automatic measure(input bit lite, output real per, output real hi);
      real t0, t1, t2;
      wait_edge(lite, 1'b1); t0 = $realtime;
      wait_edge(lite, 1'b0); t1 = $realtime;
      wait_edge(lite, 1'b1); t2 = $realtime;
      per = t2 - t0;
      hi  = t1 - t0;
   endtask

   // Expected period = max(P,1) * factor * source period
   task automatic run_case(input logic [1:0] mode, input int p, input int k,
                           input bit lite, input real tsrc, input string req);
      real per, hi, exp_per, diff;
      int  n, fac;
      @(negedge vco_clk); #1;
      src_mode = mode; p_val = 5'(p); pow_sel = 2'(k);
      repeat (3) wait_edge(lite, 1'b1);
      measure(lite, per, hi);
      n   = (p == 0) ? 1 : p;
      fac = (lite || mode == 2'd0) ? 1 : (1 << k);
      if (mode == 2'd2 && !lite) begin
         n = 1; fac = 1;
      end
      exp_per = n * fac * tsrc;
      diff = per - exp_per;
      if (diff < 0.0) diff = -diff;
      check(diff < 0.01, req, per, exp_per);
      check(hi >= 0.45 * per && hi <= 0.55 * per, "R2 duty", hi, per / 2.0);
   endtask

   initial begin
      repeat (190000) @(posedge vco_clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      real t0, t1, t2;
      // R5: outputs held low in reset
      for (int i = 0; i < 4; i++) begin
         #7;
         check(clk_out == 1'b0, "R5 reset main", real'(clk_out), 0.0);
         check(lite_out == 1'b0, "R5 reset lite", real'(lite_out), 0.0);
      end
      @(negedge vco_clk); #1;
      rst_n = 1'b1;

      // R1, R3: VCO with every ratio and every power-of-two code
      for (int k = 0; k < 4; k++)
         for (int p = 1; p < 32; p++)
            run_case(2'd1, p, k, 1'b0, TV, "R3 vco pow");

      // R1, R4: mode 0 ignores pow_sel; ratio 0 acts as 1
      for (int p = 0; p < 32; p++)
         run_case(2'd0, p, 3, 1'b0, TV, "R1 vco div");

      // R4: reference path, divided and straight through
      for (int p = 1; p < 32; p++) begin
         run_case(2'd3, p, 0, 1'b0, TR, "R4 ref div");
         run_case(2'd3, p, 3, 1'b0, TR, "R3 ref pow");
      end
      run_case(2'd2, 7, 2, 1'b0, TR, "R4 ref thru");
      run_case(2'd2, 0, 0, 1'b0, TR, "R4 ref thru p0");

      // R7: reduced variant stays VCO/N whatever the mode
      for (int p = 1; p < 10; p++) begin
         run_case(2'd2, p, 3, 1'b1, TV, "R7 lite ref mode");
         run_case(2'd3, p, 2, 1'b1, TV, "R7 lite refdiv mode");
      end

      // R6: change ratio 8 -> 3 two cycles into a period
      @(negedge vco_clk); #1;
      src_mode = 2'd0; p_val = 5'd8; pow_sel = 2'd0;
      repeat (3) @(posedge clk_out);
      @(posedge clk_out); t0 = $realtime;
      @(posedge vco_clk);
      @(posedge vco_clk);
      @(negedge vco_clk); #1;
      p_val = 5'd3;
      @(negedge clk_out); t1 = $realtime;
      @(posedge clk_out); t2 = $realtime;
      check((t1 - t0) > 79.99 && (t1 - t0) < 80.01, "R6 old high kept", t1 - t0, 80.0);
      check((t2 - t0) > 159.99 && (t2 - t0) < 160.01, "R6 old period kept", t2 - t0, 160.0);
      @(negedge clk_out); t1 = $realtime;
      @(posedge clk_out); t0 = $realtime;
      check((t0 - t2) > 59.99 && (t0 - t2) < 60.01, "R6 new period", t0 - t2, 60.0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule